// File: doc/BRIEF.md
# LIN Wake-up Pulse Generator

This block drives a LIN bus out of sleep. It holds the serial transmit line dominant (low) for a fixed number of bit times. It does this by sending one fixed UART character, so no separate pulse timer is needed. A single select bit picks the character for the protocol revision in use.

- With the newer-revision setting, the character is 0xF0. Together with the start bit it gives five dominant bits. That lasts between 250 µs and 5 ms anywhere from 1 to 20 kbit/s.
- With the older-revision setting, the character is 0x80. Together with the start bit it gives eight dominant bits.

Software pulses the start input for one cycle. The block then sends one framed character, timed by an external bit-period tick. At the end it raises a sticky completion flag. The flag stays set until a status-clear pulse removes it. Baud generation, the receive path and the bus transceiver are outside this block.

Top module: `lin_wake_gen`

## Requirements
- R1: After reset, `txd` is 1 (recessive) and `doneFlag` is 0.
- R2: With `wakeType` = 0 at acceptance, the character sent is 0xF0. The `txd` value after each successive tick is 0,0,0,0,0,1,1,1,1,1, which makes exactly five dominant bits.
- R3: With `wakeType` = 1 at acceptance, the character sent is 0x80. The `txd` value after each successive tick is 0,0,0,0,0,0,0,0,1,1, which makes exactly eight dominant bits.
- R4: A frame is one start bit (0), eight data bits sent LSB first, and one stop bit (1). After the stop bit, `txd` returns to 1 and stays there.
- R5: After a command is accepted, `txd` stays 1 until the first `bitTick`. The start bit appears in the cycle after that tick. Each later bit changes only in the cycle after a tick, so each bit lasts exactly one tick interval.
- R6: A `wakeCmd` pulse that arrives while a frame is pending or being sent is ignored. It does not change the bits sent or the completion timing.
- R7: `doneFlag` rises in the cycle after the tick that ends the stop bit. It never rises earlier.
- R8: `doneFlag` stays 1 until `clrStatus` is pulsed. It reads 0 in the cycle after the pulse.
- R9: If `clrStatus` arrives in the same cycle as completion, `doneFlag` ends up 1.
- R10: `wakeType` is sampled when the command is accepted. Changing it later has no effect on the current frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wakeCmd | input | 1 | One-cycle request to send a wake-up character |
| wakeType | input | 1 | 0: five-bit pulse (0xF0), 1: eight-bit pulse (0x80) |
| bitTick | input | 1 | One-cycle pulse per bit period |
| clrStatus | input | 1 | One-cycle request to clear the completion flag |
| txd | output | 1 | Serial transmit line, idle high |
| doneFlag | output | 1 | Sticky transfer-complete flag |

## Verification
Some properties are checked on every cycle by assertions:
- the completion flag is sticky and completion takes priority over a clear;
- the start bit follows the loading tick;
- the line holds between ticks, and control state advances only on a tick;
- a second command is ignored while a frame is pending;
- at most one control strobe fires at a time.

The bench scenarios cover what a property cannot:
- the exact dominant-bit sequences for both character choices at several tick spacings;
- the point where the select input is sampled;
- the exact completion cycle.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;

  // Strobes from the sequencer to the shifting datapath
  typedef struct packed {
    logic latchType;   // command accepted: capture the character select
    logic loadFrame;   // first tick: load the framed character, start bit out
    logic shiftBit;    // later tick: advance to the next bit
    logic finish;      // tick that ends the stop bit
  } wakeStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } wakeState_t;

endpackage

// File: rtl/lin_wake_ctrl.sv
module lin_wake_ctrl
  import lin_wake_pkg::*;
#(
  parameter int FRAME_BITS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wakeCmd,
  input  logic         bitTick,
  output wakeStrobes_t strobes
);

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  wakeState_t       state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;

  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    strobes    = '0;
    unique case (state)
      ST_IDLE: begin
        if (wakeCmd) begin
          strobes.latchType = 1'b1;
          stateNext         = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (bitTick) begin
          strobes.loadFrame = 1'b1;
          bitCntNext        = '0;
          stateNext         = ST_SEND;
        end
      end
      ST_SEND: begin
        if (bitTick) begin
          if (bitCnt == LAST_BIT) begin
            strobes.finish = 1'b1;
            bitCntNext     = '0;
            stateNext      = ST_IDLE;
          end else begin
            strobes.shiftBit = 1'b1;
            bitCntNext       = bitCnt + 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
    end
  end

  // R5
  send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && !bitTick) |=> (state == ST_SEND && $stable(bitCnt)));

  // R6
  armed_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !bitTick) |=> (state == ST_ARMED));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= LAST_BIT);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

endmodule

// File: rtl/lin_wake_dp.sv
module lin_wake_dp
  import lin_wake_pkg::*;
#(
  parameter int                 DATA_BITS = 8,
  parameter logic [DATA_BITS-1:0] NEW_CHAR = 8'hF0,
  parameter logic [DATA_BITS-1:0] OLD_CHAR = 8'h80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wakeStrobes_t strobes,
  input  logic         wakeType,
  input  logic         clrStatus,
  output logic         txd,
  output logic         doneFlag
);

  localparam int FRAME_BITS = DATA_BITS + 2;

  logic                  typeReg;
  logic [FRAME_BITS-1:0] frameBits;
  logic [FRAME_BITS-1:0] shiftReg;

  // Frame: bit 0 start (0), data LSB first, top bit stop (1)
  assign frameBits[0]            = 1'b0;
  assign frameBits[FRAME_BITS-1] = 1'b1;
  for (genvar g = 0; g < DATA_BITS; g++) begin : g_frame
    assign frameBits[g+1] = typeReg ? OLD_CHAR[g] : NEW_CHAR[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typeReg <= 1'b0;
    end else if (strobes.latchType) begin
      typeReg <= wakeType;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '1;
    end else if (strobes.loadFrame) begin
      shiftReg <= frameBits;
    end else if (strobes.shiftBit) begin
      shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
    end else if (strobes.finish) begin
      shiftReg <= '1;
    end
  end

  assign txd = shiftReg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneFlag <= 1'b0;
    end else if (strobes.finish) begin
      doneFlag <= 1'b1;
    end else if (clrStatus) begin
      doneFlag <= 1'b0;
    end
  end

  // R9
  done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.finish |=> doneFlag);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneFlag && !clrStatus) |=> doneFlag);

  // R7
  done_only_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!doneFlag && !strobes.finish) |=> !doneFlag);

  // R4
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadFrame |=> !txd);

  // R5
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.loadFrame && !strobes.shiftBit && !strobes.finish) |=> $stable(txd));

endmodule

// File: rtl/lin_wake_gen.sv
module lin_wake_gen
  import lin_wake_pkg::*;
#(
  parameter int                   DATA_BITS = 8,
  parameter logic [DATA_BITS-1:0] NEW_CHAR  = 8'hF0,
  parameter logic [DATA_BITS-1:0] OLD_CHAR  = 8'h80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wakeCmd,
  input  logic wakeType,
  input  logic bitTick,
  input  logic clrStatus,
  output logic txd,
  output logic doneFlag
);

  localparam int FRAME_BITS = DATA_BITS + 2;

  wakeStrobes_t strobes;

  lin_wake_ctrl #(
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wakeCmd(wakeCmd),
    .bitTick(bitTick),
    .strobes(strobes)
  );

  lin_wake_dp #(
    .DATA_BITS(DATA_BITS),
    .NEW_CHAR (NEW_CHAR),
    .OLD_CHAR (OLD_CHAR)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .wakeType (wakeType),
    .clrStatus(clrStatus),
    .txd      (txd),
    .doneFlag (doneFlag)
  );

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!doneFlag && $fell(doneFlag)) |-> txd);

endmodule

// File: tb/lin_wake_gen_bench.sv
module lin_wake_gen_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wakeCmd = 1'b0;
  logic wakeType = 1'b0;
  logic bitTick = 1'b0;
  logic clrStatus = 1'b0;
  logic txd;
  logic doneFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lin_wake_gen u_lin_wake_gen (
    .clk(clk), .rst_n(rst_n), .wakeCmd(wakeCmd), .wakeType(wakeType),
    .bitTick(bitTick), .clrStatus(clrStatus), .txd(txd), .doneFlag(doneFlag)
  );

  // {mode, gap cycles between ticks, txd after tick 1..10 (bit i = tick i+1)}
  localparam int NVEC = 5;
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0, 4'd3, 10'h3E0},
    {1'b1, 4'd3, 10'h300},
    {1'b0, 4'd0, 10'h3E0},
    {1'b1, 4'd1, 10'h300},
    {1'b0, 4'd6, 10'h3E0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a negedge.
  task automatic pulseTick(bit withClr);
    bitTick = 1'b1;
    clrStatus = withClr;
    @(negedge clk);
    bitTick = 1'b0;
    clrStatus = 1'b0;
  endtask

  task automatic clearFlag();
    clrStatus = 1'b1;
    @(negedge clk);
    clrStatus = 1'b0;
  endtask

  task automatic startCmd(bit mode);
    wakeCmd = 1'b1;
    wakeType = mode;
    @(negedge clk);
    wakeCmd = 0;
    check("R5 idle before first tick", 32'(txd), 32'd1);
  endtask

  // Send a whole frame; optional mid-frame command and select flip
  task automatic sendFrame(bit mode, int gap, logic [9:0] pattern,
                           bit glitch, bit flip, bit clrAtEnd);
    string req;
    req = mode ? "R3" : "R2";
    startCmd(mode);
    if (flip) wakeType = ~mode;
    repeat (2) begin
      @(negedge clk);
      check("R5 wait for tick", 32'(txd), 32'd1);
    end
    for (int i = 0; i < 10; i++) begin
      pulseTick(1'b0);
      check({req, " R4 frame bit"}, 32'(txd), 32'(pattern[i]));
      check("R7 no early done", 32'(doneFlag), 32'd0);
      for (int g = 0; g < gap; g++) begin
        if (glitch && i == 4 && g == 0) begin
          wakeCmd = 1'b1;
          wakeType = ~mode;
        end
        @(negedge clk);
        wakeCmd = 1'b0;
        check(glitch ? "R6 busy cmd ignored" : "R5 bit held",
              32'(txd), 32'(pattern[i]));
      end
    end
    pulseTick(clrAtEnd);
    check("R4 line recessive after stop", 32'(txd), 32'd1);
    check(clrAtEnd ? "R9 completion beats clear" : "R7 done after stop",
          32'(doneFlag), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset txd", 32'(txd), 32'd1);
    check("R1 reset flag", 32'(doneFlag), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release txd", 32'(txd), 32'd1);
    check("R1 after release flag", 32'(doneFlag), 32'd0);

    // Table-driven frames
    for (int v = 0; v < NVEC; v++) begin
      clearFlag();
      sendFrame(VEC[v][14], int'(VEC[v][13:10]), VEC[v][9:0], 1'b0, 1'b0, 1'b0);
    end

    // R8: flag sticky, then cleared
    repeat (5) @(negedge clk);
    check("R8 flag sticky", 32'(doneFlag), 32'd1);
    check("R4 stays idle", 32'(txd), 32'd1);
    clearFlag();
    check("R8 flag cleared", 32'(doneFlag), 32'd0);
    clearFlag();
    check("R8 clear on clear", 32'(doneFlag), 32'd0);

    // R6: command during sending ignored
    sendFrame(1'b0, 2, 10'h3E0, 1'b1, 1'b0, 1'b0);
    clearFlag();

    // R10: select flipped after acceptance has no effect
    sendFrame(1'b1, 1, 10'h300, 1'b0, 1'b1, 1'b0);
    clearFlag();

    // R6: second command while armed (other type) ignored
    startCmd(1'b0);
    wakeCmd = 1'b1;
    wakeType = 1'b1;
    @(negedge clk);
    wakeCmd = 1'b0;
    check("R6 armed cmd txd", 32'(txd), 32'd1);
    for (int i = 0; i < 10; i++) begin
      pulseTick(1'b0);
      check("R6 armed cmd ignored", 32'(txd), 32'((10'h3E0 >> i) & 1));
    end
    pulseTick(1'b0);
    check("R6 single completion", 32'(doneFlag), 32'd1);
    clearFlag();

    // R9: clear coincides with completion
    sendFrame(1'b1, 0, 10'h300, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check("R9 flag kept", 32'(doneFlag), 32'd1);

    // R4: ticks while idle leave line high
    clearFlag();
    pulseTick(1'b0);
    pulseTick(1'b0);
    check("R4 idle ticks", 32'(txd), 32'd1);
    check("R7 idle ticks no done", 32'(doneFlag), 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R0 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule